// File: doc/BRIEF.md
# Non-Speculative Block Fetch Sequencer

This block drives instruction fetch for an in-order core that never guesses the path of a program. Code is cut into regions, and each region opens with a header instruction that declares how many instructions follow it. Once the sequencer has read a header, it fetches that many instructions back to back, one per cycle. It uses no predictor and has no path to undo a fetch.

Execute may resolve a control transfer for the current region at any time while that region is still open. The sequencer stores the outcome and does not act on it until the last declared instruction has been fetched. At that boundary it fetches the next header from the stored target, or from the address just past the region. If execute has not yet reported an outcome, the sequencer stalls until it does.

A region that declares zero instructions needs no outcome. Fetch then moves straight on to the next header. If the word fetched where a header is expected is not a header, fetch halts until reset.

The controller has four states:
- `ST_HDR` fetches and decodes a header. It goes to `ST_BODY` when the length is not zero, stays in `ST_HDR` when the length is zero, and goes to `ST_HALT` when the word is not a header.
- `ST_BODY` fetches the declared instructions. On the last one it goes to `ST_HDR` if an outcome is known, or to `ST_WAIT` if it is not.
- `ST_WAIT` stalls. It goes to `ST_HDR` when an outcome arrives.
- `ST_HALT` is terminal until reset.

Top module: `bbfetch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_addr_o` equals `RESET_PC`, `fetch_vld_o` is 1, and `stall_o`, `multi_br_o` and `illegal_o` are 0.
- R2: A word is a header when bits [6:0] equal 7'h0B, bits [27:20] hold the length N, and every other bit is zero. A header is fetched with `fetch_vld_o`=1 at the address where a header is due.
- R3: After a header at address A with N>0, the next N cycles fetch A+4, A+8, ..., A+4N with `fetch_vld_o`=1 and `stall_o`=0. A resolution arriving during those cycles does not change this.
- R4: A taken resolution received during a region (body cycles or wait) moves the next header fetch to its target. That fetch happens in the cycle after the last body fetch, or in the cycle after the resolution if it came while stalled.
- R5: A not-taken resolution moves the next header fetch to A+4(N+1).
- R6: If the last body instruction has been fetched and no outcome is known, `stall_o`=1 and `fetch_vld_o`=0 in every cycle up to and including the cycle in which `res_vld_i` arrives. The header is fetched in the following cycle.
- R7: A header with N=0 is followed in the very next cycle by a header fetch at A+4, with no stall and no resolution needed.
- R8: A second resolution within the same region is ignored, so the first one decides the target. `multi_br_o` is 1 for exactly the cycle after that second resolution.
- R9: A word that is not a header, fetched where a header is due, sets `illegal_o` from the next cycle on. From then until reset, `fetch_vld_o` and `stall_o` are 0.
- R10: A resolution presented in the cycle a header is fetched is ignored. It neither ends the following region's wait nor sets its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr_o | output | AW | Address being fetched |
| fetch_vld_o | output | 1 | Fetch request this cycle |
| instr_i | input | 32 | Instruction word at `fetch_addr_o`, same cycle |
| res_vld_i | input | 1 | Control-transfer outcome strobe from execute |
| res_taken_i | input | 1 | Outcome is taken |
| res_target_i | input | AW | Target address of a taken outcome |
| stall_o | output | 1 | Fetch held waiting for an outcome |
| multi_br_o | output | 1 | Second outcome seen in one region (one-cycle pulse) |
| illegal_o | output | 1 | Non-header found where a header was due (sticky) |

## Verification
The hardest situation to reach is an outcome that lands in the last body cycle, or one that follows an earlier outcome in the same region. In both cases the stored value and the live input compete for the redirect. The random blocks choose the arrival cycle of each outcome anywhere from the first body cycle to several stall cycles after the last one, so body-end arrivals recur many times. A directed region then sends two taken outcomes with different targets. Occasional strobes in the header cycle check that outcomes outside a region are not taken.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_BODY = 2'd1,
        ST_WAIT = 2'd2,
        ST_HALT = 2'd3
    } fsm_t;
endpackage

// File: rtl/bbf_hdr_decode.sv
module bbf_hdr_decode #(
    parameter int         LEN_W   = 8,
    parameter int         LEN_POS = 20,
    parameter logic [6:0] HDR_OPC = 7'h0B
) (
    input  logic [31:0]      word_i,
    output logic             is_hdr_o,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [31:0] LEN_MASK  = ((32'd1 << LEN_W) - 32'd1) << LEN_POS;
    localparam logic [31:0] KEEP_MASK = LEN_MASK | 32'h0000_007F;

    always_comb begin
        len_o    = word_i[LEN_POS +: LEN_W];
        is_hdr_o = (word_i[6:0] == HDR_OPC) && ((word_i & ~KEEP_MASK) == 32'd0);
    end
endmodule

// File: rtl/bbf_blk_counter.sv
module bbf_blk_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/bbf_xfer_rec.sv
module bbf_xfer_rec #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          acc_en_i,
    input  logic          res_vld_i,
    input  logic          res_taken_i,
    input  logic [AW-1:0] res_target_i,
    output logic          seen_o,
    output logic          taken_o,
    output logic [AW-1:0] target_o,
    output logic          dup_o
);
    logic          seen_q;
    logic          taken_q;
    logic [AW-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            taken_q  <= 1'b0;
            target_q <= '0;
        end else if (clr_i) begin
            seen_q   <= 1'b0;
            taken_q  <= 1'b0;
        end else if (acc_en_i && res_vld_i && !seen_q) begin
            seen_q   <= 1'b1;
            taken_q  <= res_taken_i;
            target_q <= res_target_i;
        end
    end

    assign seen_o   = seen_q;
    assign taken_o  = taken_q;
    assign target_o = target_q;
    assign dup_o    = acc_en_i && res_vld_i && seen_q;
endmodule

// File: rtl/bbfetch_ctrl.sv
module bbfetch_ctrl #(
    parameter int          AW       = 32,
    parameter int          LEN_W    = 8,
    parameter int          LEN_POS  = 20,
    parameter logic [6:0]  HDR_OPC  = 7'h0B,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] fetch_addr_o,
    output logic          fetch_vld_o,
    input  logic [31:0]   instr_i,
    input  logic          res_vld_i,
    input  logic          res_taken_i,
    input  logic [AW-1:0] res_target_i,
    output logic          stall_o,
    output logic          multi_br_o,
    output logic          illegal_o
);
    import bbf_pkg::*;

    localparam logic [AW-1:0] STEP    = AW'(4);
    localparam logic [AW-1:0] BOOT_PC = AW'(RESET_PC);

    fsm_t             state_q, state_d;
    logic [AW-1:0]    pc_q, pc_d;
    logic             is_hdr;
    logic [LEN_W-1:0] hdr_len;
    logic [LEN_W-1:0] cnt_q;
    logic             cnt_last;
    logic             cnt_load, cnt_dec;
    logic             rec_clr, rec_acc;
    logic             rec_seen, rec_taken, rec_dup;
    logic [AW-1:0]    rec_target;
    logic             ill_set;
    logic             dup_q, ill_q;

    bbf_hdr_decode #(
        .LEN_W   (LEN_W),
        .LEN_POS (LEN_POS),
        .HDR_OPC (HDR_OPC)
    ) u_dec (
        .word_i   (instr_i),
        .is_hdr_o (is_hdr),
        .len_o    (hdr_len)
    );

    bbf_blk_counter #(
        .LEN_W (LEN_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (hdr_len),
        .dec_i      (cnt_dec),
        .cnt_o      (cnt_q),
        .last_o     (cnt_last)
    );

    bbf_xfer_rec #(
        .AW (AW)
    ) u_rec (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (rec_clr),
        .acc_en_i     (rec_acc),
        .res_vld_i    (res_vld_i),
        .res_taken_i  (res_taken_i),
        .res_target_i (res_target_i),
        .seen_o       (rec_seen),
        .taken_o      (rec_taken),
        .target_o     (rec_target),
        .dup_o        (rec_dup)
    );

    // State and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
            pc_q    <= BOOT_PC;
            dup_q   <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            dup_q   <= rec_dup;
            if (ill_set) begin
                ill_q <= 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        rec_clr  = 1'b0;
        ill_set  = 1'b0;
        unique case (state_q)
            ST_HDR: begin
                if (is_hdr) begin
                    cnt_load = 1'b1;
                    rec_clr  = 1'b1;
                    pc_d     = pc_q + STEP;
                    state_d  = (hdr_len == '0) ? ST_HDR : ST_BODY;
                end else begin
                    ill_set  = 1'b1;
                    state_d  = ST_HALT;
                end
            end
            ST_BODY: begin
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    if (rec_seen) begin
                        pc_d    = rec_taken ? rec_target : pc_q + STEP;
                        state_d = ST_HDR;
                    end else if (res_vld_i) begin
                        pc_d    = res_taken_i ? res_target_i : pc_q + STEP;
                        state_d = ST_HDR;
                    end else begin
                        pc_d    = pc_q + STEP;
                        state_d = ST_WAIT;
                    end
                end else begin
                    pc_d = pc_q + STEP;
                end
            end
            ST_WAIT: begin
                if (res_vld_i) begin
                    if (res_taken_i) begin
                        pc_d = res_target_i;
                    end
                    state_d = ST_HDR;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
    end

    // Outputs
    always_comb begin
        fetch_vld_o = 1'b0;
        stall_o     = 1'b0;
        rec_acc     = 1'b0;
        unique case (state_q)
            ST_HDR:  fetch_vld_o = 1'b1;
            ST_BODY: begin
                fetch_vld_o = 1'b1;
                rec_acc     = 1'b1;
            end
            ST_WAIT: begin
                stall_o = 1'b1;
                rec_acc = 1'b1;
            end
            ST_HALT: fetch_vld_o = 1'b0;
            default: fetch_vld_o = 1'b0;
        endcase
    end

    assign fetch_addr_o = pc_q;
    assign multi_br_o   = dup_q;
    assign illegal_o    = ill_q;
endmodule

// File: rtl/bbf_chk.sv
module bbf_chk #(
    parameter int         AW      = 32,
    parameter int         LEN_W   = 8,
    parameter int         LEN_POS = 20,
    parameter logic [6:0] HDR_OPC = 7'h0B
) (
    input logic             clk,
    input logic             rst_n,
    input bbf_pkg::fsm_t    state_q,
    input logic [LEN_W-1:0] cnt_q,
    input logic [AW-1:0]    fetch_addr_o,
    input logic             fetch_vld_o,
    input logic             stall_o,
    input logic [31:0]      instr_i,
    input logic             res_vld_i,
    input logic             multi_br_o,
    input logic             illegal_o
);
    import bbf_pkg::*;

    localparam logic [AW-1:0]    STEP      = AW'(4);
    localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);
    localparam logic [31:0]      SIZE_MASK = ((32'd1 << LEN_W) - 32'd1) << LEN_POS;

    logic zero_hdr;
    assign zero_hdr = (instr_i[6:0] == HDR_OPC) && ((instr_i & ~32'h0000_007F) == 32'd0)
                      && ((instr_i & SIZE_MASK) == 32'd0);

    // R3
    body_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY && cnt_q > ONE) |=> (fetch_vld_o && fetch_addr_o == $past(fetch_addr_o) + STEP));

    // R6
    stall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (!fetch_vld_o && cnt_q == '0));

    // R7
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && zero_hdr) |=> (fetch_vld_o && !stall_o && fetch_addr_o == $past(fetch_addr_o) + STEP));

    // R8
    dup_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_br_o |-> $past(res_vld_i));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> (illegal_o && !fetch_vld_o && !stall_o));
endmodule

bind bbfetch_ctrl bbf_chk #(
    .AW      (AW),
    .LEN_W   (LEN_W),
    .LEN_POS (LEN_POS),
    .HDR_OPC (HDR_OPC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .cnt_q        (cnt_q),
    .fetch_addr_o (fetch_addr_o),
    .fetch_vld_o  (fetch_vld_o),
    .stall_o      (stall_o),
    .instr_i      (instr_i),
    .res_vld_i    (res_vld_i),
    .multi_br_o   (multi_br_o),
    .illegal_o    (illegal_o)
);

// File: tb/sim_bbfetch_ctrl.sv
module sim_bbfetch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr;
    logic        fetch_vld;
    logic [31:0] instr;
    logic        res_vld = 1'b0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        stall;
    logic        multi_br;
    logic        illegal;

    logic [31:0] mem [0:255];
    int          n_chk = 0;
    int          n_fail = 0;
    string       hdr_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;
    assign instr = mem[fetch_addr[9:2]];

    bbfetch_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_addr_o (fetch_addr),
        .fetch_vld_o  (fetch_vld),
        .instr_i      (instr),
        .res_vld_i    (res_vld),
        .res_taken_i  (res_taken),
        .res_target_i (res_target),
        .stall_o      (stall),
        .multi_br_o   (multi_br),
        .illegal_o    (illegal)
    );

    function automatic logic [31:0] hdr_word(input int n);
        return {4'b0, 8'(n), 13'b0, 7'h0B};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one region starting at the current negedge; returns next header address.
    task automatic do_block(input logic [31:0] a, input int n, input bit tk,
                            input logic [31:0] tgt, input int when, input bit hdr_res,
                            output logic [31:0] nxt);
        mem[a[9:2]] = hdr_word(n);
        res_vld    = hdr_res;      // R10: strobe in header cycle must be ignored
        res_taken  = 1'b1;
        res_target = a + 32'd64;
        #1;
        check({hdr_req, " hdr addr"}, fetch_addr, a);
        check("R2 hdr vld", 32'(fetch_vld), 32'd1);
        check("R2 no stall", 32'(stall), 32'd0);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            res_vld    = (i == when);
            res_taken  = tk;
            res_target = tgt;
            #1;
            check("R3 body addr", fetch_addr, a + 32'(4 * (i + 1)));
            check("R3 body vld", 32'(fetch_vld), 32'd1);
            check("R3 body no stall", 32'(stall), 32'd0);
            check("R8 no spurious err", 32'(multi_br), 32'd0);
            @(negedge clk);
        end
        if (n > 0 && when >= n) begin
            for (int w = 0; w <= when - n; w++) begin
                res_vld    = (w == when - n);
                res_taken  = tk;
                res_target = tgt;
                #1;
                check(hdr_res ? "R10 still waiting" : "R6 stall", 32'(stall), 32'd1);
                check("R6 no fetch in stall", 32'(fetch_vld), 32'd0);
                @(negedge clk);
            end
        end
        res_vld = 1'b0;
        if (n == 0) begin
            nxt = a + 32'd4;
            hdr_req = "R7";
        end else if (tk) begin
            nxt = tgt;
            hdr_req = "R4";
        end else begin
            nxt = a + 32'(4 * (n + 1));
            hdr_req = "R5";
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        res_vld = 1'b0;
        mem[0] = hdr_word(2);
        repeat (3) @(negedge clk);
        #1;
        check("R1 addr in reset", fetch_addr, 32'd0);
        check("R1 vld in reset", 32'(fetch_vld), 32'd1);
        check("R1 flags", {29'd0, stall, multi_br, illegal}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        hdr_req = "R1";
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] pc;
        for (int k = 0; k < 256; k++) mem[k] = NOP;
        void'($urandom(32'd20240611));
        do_reset();

        // Directed: taken at body cycle 0, not-taken late, zero-size, stall long
        do_block(32'd0, 2, 1'b1, 32'h100, 0, 1'b0, pc);
        do_block(pc, 3, 1'b0, 32'h0, 2, 1'b0, pc);
        do_block(pc, 0, 1'b0, 32'h0, 0, 1'b0, pc);
        do_block(pc, 0, 1'b0, 32'h0, 0, 1'b0, pc);
        do_block(pc, 4, 1'b1, 32'h200, 9, 1'b0, pc);
        do_block(pc, 1, 1'b1, 32'h80, 0, 1'b0, pc);
        // R10: strobe in header cycle, then real not-taken outcome after stall
        do_block(pc, 2, 1'b0, 32'h0, 3, 1'b1, pc);

        // R8: two taken outcomes in one region; first wins
        mem[pc[9:2]] = hdr_word(4);
        #1;
        check({hdr_req, " hdr addr"}, fetch_addr, pc);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            res_vld    = (i == 0 || i == 2);
            res_taken  = 1'b1;
            res_target = (i == 0) ? 32'h300 : 32'h340;
            #1;
            check("R8 err timing", 32'(multi_br), (i == 3) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        res_vld = 1'b0;
        #1;
        check("R8 first target wins", fetch_addr, 32'h300);
        check("R8 pulse one cycle", 32'(multi_br), 32'd0);
        hdr_req = "R2";
        pc = 32'h300;

        // Random regions
        for (int b = 0; b < 200; b++) begin
            int  n;
            bit  tk;
            int  when;
            bit  hr;
            logic [31:0] tgt;
            n    = $urandom_range(0, 6);
            tk   = 1'($urandom_range(0, 1));
            tgt  = 32'($urandom_range(0, 255)) << 2;
            when = $urandom_range(0, n + 3);
            hr   = ($urandom_range(0, 7) == 0);
            do_block(pc, n, tk, tgt, when, hr, pc);
        end

        // R9: non-header where a header is due
        mem[pc[9:2]] = NOP;
        #1;
        check("R9 fetch of bad word", 32'(fetch_vld), 32'd1);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R9 illegal set", 32'(illegal), 32'd1);
            check("R9 fetch halted", 32'(fetch_vld), 32'd0);
            check("R9 no stall", 32'(stall), 32'd0);
            @(negedge clk);
        end

        do_reset();
        do_block(32'd0, 2, 1'b0, 32'h0, 1, 1'b0, pc);
        do_block(pc, 0, 1'b0, 32'h0, 0, 1'b0, pc);
        #1;
        check("R7 after reset", fetch_addr, pc);
        check("R1 illegal cleared", 32'(illegal), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule